// File: doc/BRIEF.md
# Programmable Video Line Delay Pair

This block supplies the three vertically aligned pixels that a 3x3 image filter needs. Pixels arrive one per clock in raster, non-interlaced order. Two equal line delays sit in series. The first tap is the incoming pixel. The second tap is the pixel from the same column one row earlier. The third tap is the pixel from two rows earlier. The length of both delays is set by one shared row-length code. A code of zero selects the deepest setting of 1024 stages. Separate logic owns the register that drives the code, so this block only reads it.

Each delay is a circular buffer: one memory and one pointer that wraps at the programmed length. The two older taps read zero until their buffer has been filled once after a reset or a frame restart. A bypass select makes the two older taps come from an external 16-bit cascade input, which allows larger frames or longer kernels. The internal two-row delay continues to run and always appears on a separate cascade output. A registered hold input freezes the whole block, and an active-low frame restart clears the pixel state without touching the configuration.

Top module: `lnd_line_pair`

## Requirements
- R1: After every accepted clock edge, `tap0_o` shows the pixel that `pix_in` held at that edge.
- R2: With bypass low, `tap1_o` after accepted pixel number k (counted from 0 since the last restart) equals pixel k-N. N is `row_len`, except that a code of 0 means N = 1024.
- R3: `cas_out_o` always shows pixel k-2N after accepted pixel k. With bypass low, `tap2_o` shows the same value. This holds whatever the bypass select is.
- R4: After a reset or a frame restart, `tap1_o` reads 0 while k < N. `tap2_o` and `cas_out_o` read 0 while k < 2N.
- R5: With `bypass` high at an accepted edge, `tap1_o` takes `cas_in[7:0]` and `tap2_o` takes `cas_in[15:8]` at that edge. The internal delays keep advancing.
- R6: `hold` is registered. When it is high at edge t, edge t+1 accepts no pixel and changes no output or pointer.
- R7: `frame_n` low at an edge clears all four outputs and restarts the pixel count at 0. It does this even while a hold is in effect. The pixel at that edge is not accepted.
- R8: `rst_n` low at an edge drives all outputs to 0, clears the registered hold and restarts the pixel count.
- R9: Row lengths 1 and 2 follow the same delay rule as larger lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Synchronous active-low frame restart |
| hold | input | 1 | Freeze request, effective one edge after it is sampled |
| bypass | input | 1 | 1: older taps come from `cas_in` |
| row_len | input | 10 | Delay length code, 0 means 1024 |
| pix_in | input | 8 | Pixel stream input |
| cas_in | input | 16 | External row data: low byte for one row back, high byte for two rows back |
| tap0_o | output | 8 | Current pixel |
| tap1_o | output | 8 | Pixel one row earlier |
| tap2_o | output | 8 | Pixel two rows earlier |
| cas_out_o | output | 8 | Internal two-row delay of the input |

## Verification
The pointer-range assertion requires that `row_len` changes only at an edge where `frame_n` is low. Otherwise a shorter length could leave the pointer beyond the new wrap point. The stimulus therefore changes the length code only together with a frame restart. The freeze and bypass assertions assume that reset and restart are low-active and synchronous. Random hold and bypass patterns, including holds that overlap a restart, keep to that assumption. Lengths of 1, 2, 5 and the code 0 are each run long enough to fill both buffers.

// File: rtl/lnd_pkg.sv
`timescale 1ns/1ps
// Package lnd_pkg
// Shared widths for the line delay pair.
// Assumes 8-bit pixels and a 3x3 window, which needs two row delays.
package lnd_pkg;
    localparam int PIX_W   = 8;
    localparam int NSTAGE  = 2;
    typedef logic [PIX_W-1:0] pix_t;
endpackage

// File: rtl/lnd_hold_ctl.sv
`timescale 1ns/1ps
// Module lnd_hold_ctl
// Registers the hold request and produces the advance enable for the block.
// Assumes: hold is sampled every edge, and only reset clears the registered copy.
module lnd_hold_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic en_o
);
    logic hold_q;

    // Capture the hold request so that it acts one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold;
    end

    assign en_o = ~hold_q;

    a_r6_hold_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && hold) |=> !en_o);
endmodule

// File: rtl/lnd_row_delay.sv
`timescale 1ns/1ps
// Module lnd_row_delay
// One line delay built as a circular buffer with a single pointer. The
// pointer wraps at eff_len, so the latency is exactly eff_len accepted
// pixels. rd_data_o is combinational (read before write) and is 0 until
// the buffer has been filled once after a clear.
// Assumes: eff_len lies in 1..DEPTH and changes only while clr is high.
module lnd_row_delay
    import lnd_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int LEN_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [LEN_W:0]   eff_len,
    input  pix_t             wr_data_i,
    output pix_t             rd_data_o
);
    localparam int CNT_W = LEN_W + 1;

    pix_t             mem [DEPTH];
    logic [LEN_W-1:0] ptr;
    logic             filled;
    logic             at_wrap;

    assign at_wrap = ({1'b0, ptr} >= (eff_len - CNT_W'(1)));

    // Advance the pointer and record the first complete pass.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr    <= '0;
            filled <= 1'b0;
        end else if (en) begin
            if (at_wrap) begin
                ptr    <= '0;
                filled <= 1'b1;
            end else begin
                ptr <= ptr + LEN_W'(1);
            end
        end
    end

    // Store the incoming pixel at the current slot.
    always_ff @(posedge clk) begin
        if (en) mem[ptr] <= wr_data_i;
    end

    // Return the oldest stored pixel, or zero before the first full pass.
    assign rd_data_o = filled ? mem[ptr] : '0;

    a_r2_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n || clr)
        ({1'b0, ptr} < eff_len));
endmodule

// File: rtl/lnd_line_pair.sv
`timescale 1ns/1ps
// Module lnd_line_pair
// Two line delays in series that give three vertically aligned taps for a
// 3x3 window. They also give a cascade output of the two-row delay. The
// bypass select takes the older taps from an external cascade input instead.
// Assumes: raster input with one pixel per accepted edge, and row_len changed
// only together with a frame restart.
module lnd_line_pair
    import lnd_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int LEN_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_n,
    input  logic                  hold,
    input  logic                  bypass,
    input  logic [LEN_W-1:0]      row_len,
    input  logic [PIX_W-1:0]      pix_in,
    input  logic [2*PIX_W-1:0]    cas_in,
    output logic [PIX_W-1:0]      tap0_o,
    output logic [PIX_W-1:0]      tap1_o,
    output logic [PIX_W-1:0]      tap2_o,
    output logic [PIX_W-1:0]      cas_out_o
);
    localparam int CNT_W = LEN_W + 1;

    logic             en;
    logic [CNT_W-1:0] eff_len;
    pix_t             chain [NSTAGE+1];
    pix_t             cas_lo;
    pix_t             cas_hi;

    assign cas_lo = cas_in[PIX_W-1:0];
    assign cas_hi = cas_in[2*PIX_W-1:PIX_W];

    // Decode the length code: zero selects the full depth.
    assign eff_len = (row_len == '0) ? CNT_W'(DEPTH) : {1'b0, row_len};

    lnd_hold_ctl u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold),
        .en_o  (en)
    );

    assign chain[0] = pix_in;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        lnd_row_delay #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_dly (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (~frame_n),
            .en        (en),
            .eff_len   (eff_len),
            .wr_data_i (chain[g]),
            .rd_data_o (chain[g+1])
        );
    end

    // Register the aligned taps and pick internal or external older rows.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_n) begin
            tap0_o    <= '0;
            tap1_o    <= '0;
            tap2_o    <= '0;
            cas_out_o <= '0;
        end else if (en) begin
            tap0_o    <= pix_in;
            tap1_o    <= bypass ? cas_lo : chain[1];
            tap2_o    <= bypass ? cas_hi : chain[2];
            cas_out_o <= chain[2];
        end
    end

    a_r6_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && frame_n && !en) |=>
        ($stable(tap0_o) && $stable(tap1_o) && $stable(tap2_o) && $stable(cas_out_o)));

    a_r7_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !frame_n) |=>
        (tap0_o == '0 && tap1_o == '0 && tap2_o == '0 && cas_out_o == '0));

    a_r5_bypass_taps: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && frame_n && en && bypass) |=>
        (tap1_o == $past(cas_lo) && tap2_o == $past(cas_hi)));
endmodule

// File: tb/lnd_line_pair_tb_top.sv
`timescale 1ns/1ps
module lnd_line_pair_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, frame_n, hold, bypass;
    logic [9:0]  row_len;
    logic [7:0]  pix_in;
    logic [15:0] cas_in;
    logic [7:0]  tap0_o, tap1_o, tap2_o, cas_out_o;

    always #2.5 clk = ~clk;

    lnd_line_pair dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .hold(hold),
        .bypass(bypass), .row_len(row_len), .pix_in(pix_in), .cas_in(cas_in),
        .tap0_o(tap0_o), .tap1_o(tap1_o), .tap2_o(tap2_o), .cas_out_o(cas_out_o)
    );

    int checks = 0;
    int fails = 0;
    logic [7:0] hist [8192];
    int hq = 0;
    int cnt = 0;
    logic [7:0] e0 = 0, e1 = 0, e2 = 0, ec = 0;
    string ctx = "";
    string t0, t1, t2, tc;

    function automatic int len_of(logic [9:0] code);
        return (code == 10'd0) ? 1024 : int'(code);
    endfunction

    function automatic logic [7:0] back(int k, int d);
        return (k >= d) ? hist[(k - d) % 8192] : 8'h00;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (k=%0d)", tag, what, act, exp, cnt);
        end
    endtask

    // One clock edge: update the reference model, then compare after the edge.
    task automatic cyc();
        int n;
        @(posedge clk);
        n = len_of(row_len);
        t0 = "R1"; t1 = bypass ? "R5" : (n <= 2 ? "R9" : (cnt < n ? "R4" : "R2"));
        t2 = bypass ? "R5" : (n <= 2 ? "R9" : (cnt < 2*n ? "R4" : "R3"));
        tc = (cnt < 2*n) ? "R4" : "R3";
        if (!rst_n) begin
            e0 = 0; e1 = 0; e2 = 0; ec = 0; cnt = 0; hq = 0;
        end else if (!frame_n) begin
            e0 = 0; e1 = 0; e2 = 0; ec = 0; cnt = 0; hq = int'(hold);
        end else begin
            if (hq == 0) begin
                hist[cnt % 8192] = pix_in;
                e0 = pix_in;
                e1 = bypass ? cas_in[7:0]  : back(cnt, n);
                e2 = bypass ? cas_in[15:8] : back(cnt, 2*n);
                ec = back(cnt, 2*n);
                cnt++;
            end else begin
                t0 = "R6"; t1 = "R6"; t2 = "R6"; tc = "R6";
            end
            hq = int'(hold);
        end
        if (ctx != "") begin t0 = ctx; t1 = ctx; t2 = ctx; tc = ctx; end
        #1;
        chk(t0, tap0_o, e0, "tap0");
        chk(t1, tap1_o, e1, "tap1");
        chk(t2, tap2_o, e2, "tap2");
        chk(tc, cas_out_o, ec, "cas_out");
        @(negedge clk);
    endtask

    task automatic restart(logic [9:0] code, string tag);
        row_len = code; frame_n = 0; ctx = tag; cyc(); frame_n = 1; ctx = "";
    endtask

    task automatic run(int cycles, int hold_mod, int byp_mod);
        for (int i = 0; i < cycles; i++) begin
            pix_in = 8'($urandom);
            cas_in = 16'($urandom);
            hold   = (hold_mod > 0) && ($urandom % hold_mod == 0);
            bypass = (byp_mod > 0) && ($urandom % byp_mod == 0);
            cyc();
        end
        hold = 0; bypass = 0;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; frame_n = 1; hold = 0; bypass = 0; row_len = 10'd5;
        pix_in = 8'h5A; cas_in = 16'hA5C3;
        @(negedge clk);
        ctx = "R8"; cyc(); cyc(); cyc(); ctx = "";
        rst_n = 1;
        restart(10'd5, "R7");
        run(300, 8, 5);
        // directed hold: raise for two edges, outputs must freeze
        pix_in = 8'h11; hold = 1; cyc();
        pix_in = 8'h22; ctx = "R6"; cyc(); hold = 0; pix_in = 8'h33; cyc(); ctx = "";
        cyc();
        // restart while a hold is active
        hold = 1; cyc();
        frame_n = 0; ctx = "R7"; cyc(); frame_n = 1; hold = 0; ctx = "";
        run(40, 0, 0);
        restart(10'd1, "R7"); run(40, 6, 7);
        restart(10'd2, "R7"); run(40, 6, 7);
        restart(10'd7, "R7"); run(120, 0, 3);
        restart(10'd0, "R7"); run(2300, 20, 0);
        // reset mid-run with hold pending
        hold = 1; cyc();
        rst_n = 0; hold = 0; ctx = "R8"; cyc(); rst_n = 1; ctx = "";
        restart(10'd4, "R7"); run(60, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule